// File: doc/BRIEF.md
# Low-Power State Controller with Wake Guard

This block sequences a converter through its power-saving states and keeps conversions from starting while the circuitry is still settling. Two level inputs ask for a light sleep state (core off, reference kept on) or a deep sleep state (core and reference both off). When the requests fall away, the block powers the core back up. It then counts a settling interval in clock cycles, and only after that interval does it raise its ready flag.

The length of the interval depends on two things. One is whether the reference was switched off at any point since the block was last ready. The other is a strap that says an external reference stays powered throughout. A conversion request made while ready is low is blocked, and the block reports it with a one-cycle error pulse. A request made while ready is high is passed on as a one-cycle start pulse.

Top module: `pwr_wake_guard`

## Requirements
- R1: After reset, ready, ref_pwr_en and core_pwr_en are 1, and early_err and conv_go are 0.
- R2: A clock edge that samples nap_req=1 with stby_req=0 makes the state light sleep from that edge on: core_pwr_en=0, ref_pwr_en=1, ready=0.
- R3: A clock edge that samples stby_req=1 makes the state deep sleep from that edge on: core_pwr_en=0, ref_pwr_en=0, ready=0.
- R4: When nap_req and stby_req are both 1, deep sleep is taken, so ref_pwr_en goes to 0.
- R5: The first edge that samples both requests at 0 after light sleep turns core_pwr_en on. ready then stays 0 for exactly NAP_CYC cycles and rises on the next edge, provided the reference was not off since the last ready.
- R6: After deep sleep with ext_ref_on=0 sampled on the exit edge, ready stays 0 for exactly STBY_CYC cycles.
- R7: After deep sleep with ext_ref_on=1 sampled on the exit edge, ready stays 0 for exactly NAP_CYC cycles.
- R8: Once deep sleep has been entered, any later exit (including from light sleep) uses the STBY_CYC interval when ext_ref_on=0. This holds until ready has risen again.
- R9: A sleep request that arrives during the settling interval returns the block to that sleep state. The next exit restarts the full interval.
- R10: conv_req=1 sampled while ready=1 gives conv_go=1 and early_err=0 in the following cycle.
- R11: conv_req=1 sampled while ready=0 gives early_err=1 and conv_go=0 in the following cycle. The pulse lasts one cycle for each request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nap_req | input | 1 | Light sleep request (level) |
| stby_req | input | 1 | Deep sleep request (level) |
| ext_ref_on | input | 1 | Strap: an external reference stays powered |
| conv_req | input | 1 | Conversion start request (strobe) |
| ref_pwr_en | output | 1 | Reference power enable |
| core_pwr_en | output | 1 | Core power enable |
| ready | output | 1 | Settling complete; conversions allowed |
| conv_go | output | 1 | Accepted conversion start pulse |
| early_err | output | 1 | Blocked premature start pulse |

## Verification
The power enables and ready follow the state register, so they change on the edge that samples a request. conv_go and early_err appear one edge after the conv_req they answer. ready rises exactly the interval length in cycles after the exit edge. A behavioural model in the bench advances on the same edge as the design, and every output is compared at the falling edge that follows. Directed checks also count the falling edges at which ready is low after each exit and compare that count with NAP_CYC or STBY_CYC.

// File: rtl/pwr_wake_guard.sv
module pwr_wake_guard #(
  parameter int NAP_CYC  = 5,
  parameter int STBY_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nap_req,
  input  logic stby_req,
  input  logic ext_ref_on,
  input  logic conv_req,
  output logic ref_pwr_en,
  output logic core_pwr_en,
  output logic ready,
  output logic conv_go,
  output logic early_err
);
  localparam int MAXC = (STBY_CYC > NAP_CYC) ? STBY_CYC : NAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] NAP_LD  = CW'(NAP_CYC - 1);
  localparam logic [CW-1:0] STBY_LD = CW'(STBY_CYC - 1);

  typedef enum logic [1:0] {S_AWAKE, S_NAP, S_STBY, S_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          ref_cold;

  wire asleep = (st == S_NAP) || (st == S_STBY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_AWAKE;
      cnt      <= '0;
      ref_cold <= 1'b0;
    end else if (stby_req) begin
      st       <= S_STBY;
      ref_cold <= 1'b1;
    end else if (nap_req) begin
      st <= S_NAP;
    end else if (asleep) begin
      st  <= S_WAKE;
      cnt <= (ref_cold && !ext_ref_on) ? STBY_LD : NAP_LD;
    end else if (st == S_WAKE) begin
      if (cnt == '0) begin
        st       <= S_AWAKE;
        ref_cold <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_go   <= 1'b0;
      early_err <= 1'b0;
    end else begin
      conv_go   <= conv_req && (st == S_AWAKE);
      early_err <= conv_req && (st != S_AWAKE);
    end
  end

  assign ready       = (st == S_AWAKE);
  assign core_pwr_en = (st == S_AWAKE) || (st == S_WAKE);
  assign ref_pwr_en  = (st != S_STBY);

  // R2
  nap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nap_req && !stby_req |=> ref_pwr_en && !core_pwr_en && !ready);
  // R3
  stby_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |=> !ref_pwr_en && !core_pwr_en && !ready);
  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> core_pwr_en && ref_pwr_en && $past(!nap_req && !stby_req));
  // R10
  conv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && ready |=> conv_go && !early_err);
  // R11
  conv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !ready |=> early_err && !conv_go);
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_req |=> !early_err && !conv_go);
endmodule

// File: tb/pwr_wake_guard_tb_top.sv
module pwr_wake_guard_tb_top;
  localparam int NAP  = 4;
  localparam int STBY = 30;

  logic clk = 0, rst_n = 0;
  logic nap_req = 0, stby_req = 0, ext_ref_on = 0, conv_req = 0;
  logic ref_pwr_en, core_pwr_en, ready, conv_go, early_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_wake_guard #(.NAP_CYC(NAP), .STBY_CYC(STBY)) dut_i (
    .clk(clk), .rst_n(rst_n), .nap_req(nap_req), .stby_req(stby_req),
    .ext_ref_on(ext_ref_on), .conv_req(conv_req), .ref_pwr_en(ref_pwr_en),
    .core_pwr_en(core_pwr_en), .ready(ready), .conv_go(conv_go),
    .early_err(early_err));

  // behavioural model: 0 awake, 1 light sleep, 2 deep sleep, 3 settling
  int m_mode = 0, m_left = 0;
  bit m_cold = 0, m_go = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_cold = 0; m_go = 0; m_err = 0;
    end else begin
      m_go  = conv_req && (m_mode == 0);
      m_err = conv_req && (m_mode != 0);
      if (stby_req) begin m_mode = 2; m_cold = 1; end
      else if (nap_req) m_mode = 1;
      else if (m_mode == 1 || m_mode == 2) begin
        m_mode = 3;
        m_left = (m_cold && !ext_ref_on) ? STBY : NAP;
      end else if (m_mode == 3) begin
        m_left--;
        if (m_left == 0) begin m_mode = 0; m_cold = 0; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R3/R4 ref_pwr_en", ref_pwr_en, m_mode != 2);
    chk("R5/R6 core_pwr_en", core_pwr_en, m_mode == 0 || m_mode == 3);
    chk("R5/R6/R7/R8/R9 ready", ready, m_mode == 0);
    chk("R10 conv_go", conv_go, m_go);
    chk("R11 early_err", early_err, m_err);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic settle(input string req, input int exp);
    int n = 0;
    nap_req = 0; stby_req = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
    #1;
    chk(req, n, exp);
  endtask

  initial begin
    step(3);
    chk("R1 ready", ready, 1); chk("R1 ref_pwr_en", ref_pwr_en, 1);
    chk("R1 core_pwr_en", core_pwr_en, 1);
    chk("R1 conv_go", conv_go, 0); chk("R1 early_err", early_err, 0);
    rst_n = 1; step(2);
    // R10 accepted start
    conv_req = 1; step(1); conv_req = 0;
    chk("R10 go", conv_go, 1); step(1);
    // R2 light sleep, R11 blocked start
    nap_req = 1; step(3);
    chk("R2 core off", core_pwr_en, 0); chk("R2 ref on", ref_pwr_en, 1);
    conv_req = 1; step(1); conv_req = 0;
    chk("R11 err", early_err, 1); chk("R11 no go", conv_go, 0);
    step(1); chk("R11 one pulse", early_err, 0);
    settle("R5 nap interval", NAP); step(2);
    // R6 deep sleep internal reference
    stby_req = 1; step(3);
    chk("R3 ref off", ref_pwr_en, 0);
    settle("R6 deep interval", STBY); step(2);
    // R7 deep sleep with external reference
    ext_ref_on = 1; stby_req = 1; step(3);
    settle("R7 ext ref interval", NAP); ext_ref_on = 0; step(2);
    // R4 both requests
    nap_req = 1; stby_req = 1; step(2);
    chk("R4 deep wins", ref_pwr_en, 0);
    // R8 deep then light then exit
    stby_req = 0; step(3);
    chk("R8 ref back on", ref_pwr_en, 1);
    settle("R8 long interval", STBY); step(2);
    // R9 interruption during settling
    nap_req = 1; step(2); nap_req = 0; step(2);
    conv_req = 1; step(1); conv_req = 0;
    chk("R11 early during settle", early_err, 1);
    nap_req = 1; step(2);
    settle("R9 restart", NAP); step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule